// File: doc/BRIEF.md
# Two-Bit Ripple Arithmetic Slice

This block is a 2-bit arithmetic cell of the kind that fills one slice of a programmable-logic fabric running in its arithmetic configuration. A three-bit mode input picks what it does. It can add, subtract, or add or subtract as chosen at run time by one control pin. It can also run a 2-bit counter that counts up, down, or in a direction picked at run time. The counter has an asynchronous clear and a synchronous preload.

Three comparison flags report how operand A relates to operand B in every mode. The flags come from a dedicated subtract path, using its carry-out and a zero test on its difference. Besides the ripple carry-out, the cell exports a slice-level carry generate and carry propagate. An outside fast-carry network can use these to chain many slices without waiting for the ripple.

All pins are plain control and data levels with no handshake. The arithmetic outputs are combinational in the operands, and the counter state is the only storage. A wider adder is built by chaining `carry_out` of one slice into `carry_in` of the next, or by feeding each slice's generate and propagate into a lookahead network.

Top module: `arith_slice2`

## Requirements
- R1: With `mode` = 0 (add) or 7 (spare, treated as add), `{carry_out, result}` equals `op_a + op_b + carry_in`.
- R2: With `mode` = 1 (subtract), `result` is `(op_a - op_b) mod 4`, computed as `op_a + ~op_b + 1`. `carry_out` is 1 exactly when `op_a >= op_b` (no borrow). `carry_in` has no effect.
- R3: With `mode` = 2 (run-time add/subtract), `sub_ctl` = 0 gives the R1 behaviour and `sub_ctl` = 1 gives the R2 behaviour.
- R4: In modes 0, 1, 2, 6 and 7, with per-bit g = a & b' and p = a ^ b' (b' is `op_b` inverted when subtracting or comparing), `slice_gen` = g1 | (p1 & g0) and `slice_prop` = p1 & p0. `carry_out` then equals `slice_gen | (slice_prop & c)`, where c is the effective carry-in (1 when subtracting). Four slices chained this way form an 8-bit adder. In counter modes both outputs are 0.
- R5: With `mode` = 3 (count up) and `cnt_en` = 1, the count rises by one at each clock edge and wraps from 3 to 0. `carry_out` is 1 during the cycle the count is 3.
- R6: With `mode` = 4 (count down) and `cnt_en` = 1, the count falls by one at each edge and wraps from 0 to 3. `carry_out` is 1 during the cycle the count is 0.
- R7: With `mode` = 5 (up/down), `sub_ctl` = 0 counts up and `sub_ctl` = 1 counts down.
- R8: `cnt_clr` = 1 forces the count to 0 at once, without a clock edge. It outranks a preload.
- R9: In a counter mode, `cnt_load` = 1 loads `op_a` into the count at the next edge. It outranks counting, and `carry_out` stays 0 during that cycle.
- R10: In every mode, `cmp_ge`, `cmp_ne` and `cmp_le` report `op_a >= op_b`, `op_a != op_b` and `op_a <= op_b`.
- R11: While `rst_n` is low, the count is 0.
- R12: Outside counter modes, and with `cnt_en` = 0, the count holds. `result` shows the count only in modes 3 to 5.
- R13: In mode 6 (compare), `result` is the difference `op_a - op_b` mod 4 and `carry_out` equals `cmp_ge`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Function select (0 add, 1 sub, 2 add/sub, 3 up, 4 down, 5 up/down, 6 compare, 7 add) |
| sub_ctl | input | 1 | Run-time subtract select in mode 2; down select in mode 5 |
| op_a | input | 2 | Operand A, also the preload value |
| op_b | input | 2 | Operand B |
| carry_in | input | 1 | Ripple carry into the slice |
| cnt_en | input | 1 | Counter step enable |
| cnt_load | input | 1 | Synchronous preload of `op_a` into the count |
| cnt_clr | input | 1 | Asynchronous clear of the count, active high |
| result | output | 2 | Sum, difference or count |
| carry_out | output | 1 | Ripple carry-out, or counter terminal carry |
| slice_gen | output | 1 | Slice carry generate |
| slice_prop | output | 1 | Slice carry propagate |
| cmp_ge | output | 1 | A greater than or equal to B |
| cmp_ne | output | 1 | A not equal to B |
| cmp_le | output | 1 | A less than or equal to B |

## Verification
The only stored state is the 2-bit count. A wrong value there shows on `result` during the same cycle whenever a counter mode is selected. It also shows on `carry_out` through the terminal-carry test, one edge after the faulty step.

Faults in the arithmetic and compare paths are combinational. They show at the ports as soon as the operands settle. A generate or propagate that disagrees with the ripple carry is caught by chaining four slices and comparing the lookahead carry against the true 8-bit carry.

// File: rtl/arith_slice_pkg.sv
package arith_slice_pkg;

  typedef enum logic [2:0] {
    MODE_ADD     = 3'd0,
    MODE_SUB     = 3'd1,
    MODE_ADDSUB  = 3'd2,
    MODE_CNT_UP  = 3'd3,
    MODE_CNT_DN  = 3'd4,
    MODE_CNT_UD  = 3'd5,
    MODE_CMP     = 3'd6,
    MODE_SPARE   = 3'd7
  } slice_mode_e;

  function automatic logic mode_is_counter(slice_mode_e m);
    return (m == MODE_CNT_UP) || (m == MODE_CNT_DN) || (m == MODE_CNT_UD);
  endfunction

endpackage

// File: rtl/slice_ripple_add.sv
module slice_ripple_add #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         grp_gen,
  output logic         grp_prop
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W:0]   chain;

  assign chain[0] = cin;

  // per-bit generate/propagate and ripple stage
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_g[i]   = a[i] & b[i];
    assign bit_p[i]   = a[i] ^ b[i];
    assign sum[i]     = bit_p[i] ^ chain[i];
    assign chain[i+1] = bit_g[i] | (bit_p[i] & chain[i]);
  end

  assign cout = chain[W];

  // group generate/propagate folded from the least significant bit upward
  always_comb begin
    logic g_acc;
    logic p_acc;
    g_acc = bit_g[0];
    p_acc = bit_p[0];
    for (int k = 1; k < W; k++) begin
      g_acc = bit_g[k] | (bit_p[k] & g_acc);
      p_acc = bit_p[k] & p_acc;
    end
    grp_gen  = g_acc;
    grp_prop = p_acc;
  end

endmodule

// File: rtl/slice_compare.sv
module slice_compare #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ge,
  output logic         ne,
  output logic         le,
  output logic         no_borrow
);

  logic [W-1:0] diff;
  logic         grp_g;
  logic         grp_p;

  // dedicated subtract path: a + ~b + 1
  slice_ripple_add #(.W(W)) u_sub (
    .a        (a),
    .b        (~b),
    .cin      (1'b1),
    .sum      (diff),
    .cout     (no_borrow),
    .grp_gen  (grp_g),
    .grp_prop (grp_p)
  );

  // carry-in is 1, so the group carry is generate | propagate
  assign ge = grp_g | grp_p;
  assign ne = |diff;
  assign le = ~(ge & ne);

endmodule

// File: rtl/slice_counter.sv
module slice_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic         down,
  output logic [W-1:0] count,
  output logic         term
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = W'(1);

  // priority: async clear, then preload, then step
  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (en) begin
      count <= down ? (count - CNT_ONE) : (count + CNT_ONE);
    end
  end

  assign term = en & ~load & (down ? (count == '0) : (count == CNT_MAX));

  AST_CNT_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (en && !load && !down) |=> count == W'($past(count) + CNT_ONE)); // R5

  AST_CNT_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (en && !load && down) |=> count == W'($past(count) - CNT_ONE)); // R6

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    load |=> count == $past(load_val)); // R9

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (!en && !load) |=> $stable(count)); // R12

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> count == '0); // R8

endmodule

// File: rtl/arith_slice2.sv
module arith_slice2
  import arith_slice_pkg::*;
#(
  parameter int SLICE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         mode,
  input  logic               sub_ctl,
  input  logic [SLICE_W-1:0] op_a,
  input  logic [SLICE_W-1:0] op_b,
  input  logic               carry_in,
  input  logic               cnt_en,
  input  logic               cnt_load,
  input  logic               cnt_clr,
  output logic [SLICE_W-1:0] result,
  output logic               carry_out,
  output logic               slice_gen,
  output logic               slice_prop,
  output logic               cmp_ge,
  output logic               cmp_ne,
  output logic               cmp_le
);

  slice_mode_e  mode_q;
  logic         is_cnt;
  logic         do_sub;
  logic         cnt_down;
  logic [SLICE_W-1:0] b_eff;
  logic         cin_eff;
  logic [SLICE_W-1:0] sum;
  logic         sum_cout;
  logic         add_g;
  logic         add_p;
  logic [SLICE_W-1:0] count;
  logic         cnt_term;
  logic         cmp_nb;

  assign mode_q = slice_mode_e'(mode);
  assign is_cnt = mode_is_counter(mode_q);

  always_comb begin
    unique case (mode_q)
      MODE_SUB, MODE_CMP: do_sub = 1'b1;
      MODE_ADDSUB:        do_sub = sub_ctl;
      default:            do_sub = 1'b0;
    endcase
  end

  assign cnt_down = (mode_q == MODE_CNT_DN) | ((mode_q == MODE_CNT_UD) & sub_ctl);
  assign b_eff    = do_sub ? ~op_b : op_b;
  assign cin_eff  = do_sub | carry_in;

  slice_ripple_add #(.W(SLICE_W)) u_add (
    .a        (op_a),
    .b        (b_eff),
    .cin      (cin_eff),
    .sum      (sum),
    .cout     (sum_cout),
    .grp_gen  (add_g),
    .grp_prop (add_p)
  );

  slice_counter #(.W(SLICE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .load     (cnt_load & is_cnt),
    .load_val (op_a),
    .en       (cnt_en & is_cnt),
    .down     (cnt_down),
    .count    (count),
    .term     (cnt_term)
  );

  slice_compare #(.W(SLICE_W)) u_cmp (
    .a         (op_a),
    .b         (op_b),
    .ge        (cmp_ge),
    .ne        (cmp_ne),
    .le        (cmp_le),
    .no_borrow (cmp_nb)
  );

  assign result     = is_cnt ? count    : sum;
  assign carry_out  = is_cnt ? cnt_term : sum_cout;
  assign slice_gen  = is_cnt ? 1'b0     : add_g;
  assign slice_prop = is_cnt ? 1'b0     : add_p;

  AST_CARRY_GP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cnt |-> carry_out == (slice_gen | (slice_prop & cin_eff))); // R4

  AST_CMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ge | cmp_le) && ((cmp_ge & cmp_le) == !cmp_ne)); // R10

  AST_CMP_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ge == cmp_nb); // R10

  AST_CMP_MODE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CMP) |-> carry_out == cmp_ge); // R13

endmodule

// File: tb/tb_arith_slice2.sv
module tb_arith_slice2;

  localparam logic [2:0] M_ADD = 3'd0, M_SUB = 3'd1, M_ADDSUB = 3'd2, M_UP = 3'd3,
                         M_DN = 3'd4, M_UD = 3'd5, M_CMP = 3'd6, M_SPARE = 3'd7;

  // {mode, sub_ctl, a, b, cin, exp_result, exp_cout, exp_gen, exp_prop}
  localparam int NVEC = 8;
  localparam logic [13:0] VEC [NVEC] = '{
    {M_ADD,    1'b0, 2'd1, 2'd2, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1},
    {M_ADD,    1'b0, 2'd3, 2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0},
    {M_SUB,    1'b0, 2'd2, 2'd3, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0},
    {M_SUB,    1'b0, 2'd3, 2'd1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0},
    {M_ADDSUB, 1'b1, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1},
    {M_ADDSUB, 1'b0, 2'd2, 2'd2, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0},
    {M_SPARE,  1'b0, 2'd2, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1},
    {M_CMP,    1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = M_UP;
  logic sub_ctl = 1'b0;
  logic [1:0] op_a = '0, op_b = '0;
  logic carry_in = 1'b0;
  logic cnt_en = 1'b0, cnt_load = 1'b0, cnt_clr = 1'b0;
  logic [1:0] result;
  logic carry_out, slice_gen, slice_prop, cmp_ge, cmp_ne, cmp_le;

  // upper slices of the cascade
  logic [1:0] ca [1:3];
  logic [1:0] cb [1:3];
  logic [1:0] cres [1:3];
  logic [3:0] cc;
  logic [1:3] cg, cp, cge, cne, cle;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  arith_slice2 dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sub_ctl(sub_ctl), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .cnt_en(cnt_en), .cnt_load(cnt_load), .cnt_clr(cnt_clr),
    .result(result), .carry_out(carry_out), .slice_gen(slice_gen), .slice_prop(slice_prop),
    .cmp_ge(cmp_ge), .cmp_ne(cmp_ne), .cmp_le(cmp_le)
  );

  assign cc[0] = carry_out;

  for (genvar s = 1; s <= 3; s++) begin : g_casc
    arith_slice2 u_s (
      .clk(clk), .rst_n(rst_n), .mode(M_ADD), .sub_ctl(1'b0), .op_a(ca[s]), .op_b(cb[s]),
      .carry_in(cc[s-1]), .cnt_en(1'b0), .cnt_load(1'b0), .cnt_clr(1'b0),
      .result(cres[s]), .carry_out(cc[s]), .slice_gen(cg[s]), .slice_prop(cp[s]),
      .cmp_ge(cge[s]), .cmp_ne(cne[s]), .cmp_le(cle[s])
    );
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int exp_cnt;

    // reset state (R11)
    repeat (2) @(posedge clk);
    #2;
    chk(result == 2'd0, "R11 count in reset", result, 0);
    chk(carry_out == 1'b0, "R11 carry in reset", carry_out, 0);
    rst_n = 1'b1;
    tick();
    chk(result == 2'd0, "R11 count after reset", result, 0);

    // vector table (R1 R2 R3 R4 R13)
    for (int i = 0; i < NVEC; i++) begin
      {mode, sub_ctl, op_a, op_b, carry_in} = VEC[i][13:5];
      #1;
      chk(result == VEC[i][4:3], "R1/R2/R3 vector result", result, VEC[i][4:3]);
      chk(carry_out == VEC[i][2], "R1/R2/R3 vector carry", carry_out, VEC[i][2]);
      chk(slice_gen == VEC[i][1], "R4 vector gen", slice_gen, VEC[i][1]);
      chk(slice_prop == VEC[i][0], "R4 vector prop", slice_prop, VEC[i][0]);
    end

    // exhaustive 2-bit operand sweeps
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int c = 0; c < 2; c++) begin
          int s;
          int d;
          logic [1:0] bi;
          logic [1:0] av;
          av = 2'(a);
          op_a = 2'(a); op_b = 2'(b); carry_in = c[0];
          s = a + b + c;
          d = (a - b + 4) % 4;

          mode = M_ADD; sub_ctl = 1'b0; #1;
          chk(result == 2'(s), "R1 sum", result, s % 4);
          chk(carry_out == (s > 3), "R1 carry", carry_out, int'(s > 3));
          bi = 2'(b);
          chk(slice_gen == ((av[1] & bi[1]) | ((av[1] ^ bi[1]) & av[0] & bi[0])),
              "R4 gen add", slice_gen, 0);
          chk(slice_prop == ((av[1] ^ bi[1]) & (av[0] ^ bi[0])), "R4 prop add", slice_prop, 0);

          mode = M_SPARE; #1;
          chk(result == 2'(s) && carry_out == (s > 3), "R1 spare mode", result, s % 4);

          mode = M_SUB; #1;
          chk(result == 2'(d), "R2 diff", result, d);
          chk(carry_out == (a >= b), "R2 no-borrow, carry_in ignored", carry_out, int'(a >= b));
          bi = ~2'(b);
          chk(slice_gen == ((av[1] & bi[1]) | ((av[1] ^ bi[1]) & av[0] & bi[0])),
              "R4 gen sub", slice_gen, 0);
          chk(slice_prop == ((av[1] ^ bi[1]) & (av[0] ^ bi[0])), "R4 prop sub", slice_prop, 0);

          mode = M_ADDSUB; sub_ctl = 1'b0; #1;
          chk(result == 2'(s) && carry_out == (s > 3), "R3 add select", result, s % 4);
          sub_ctl = 1'b1; #1;
          chk(result == 2'(d) && carry_out == (a >= b), "R3 sub select", result, d);

          mode = M_CMP; sub_ctl = 1'b0; #1;
          chk(cmp_ge == (a >= b), "R10 ge", cmp_ge, int'(a >= b));
          chk(cmp_ne == (a != b), "R10 ne", cmp_ne, int'(a != b));
          chk(cmp_le == (a <= b), "R10 le", cmp_le, int'(a <= b));
          chk(result == 2'(d) && carry_out == (a >= b), "R13 compare mode", result, d);
        end
      end
    end

    // four slices chained as an 8-bit adder (R4)
    for (int i = 0; i < 200; i++) begin
      logic [7:0] av;
      logic [7:0] bv;
      logic [8:0] exp_sum;
      logic [7:0] got;
      logic [3:0] gg;
      logic [3:0] pp;
      logic lc;
      av = 8'((i * 37 + 11) % 256);
      bv = 8'((i * 91 + 5) % 256);
      mode = M_ADD; sub_ctl = 1'b0;
      carry_in = i[0];
      op_a = av[1:0]; op_b = bv[1:0];
      ca[1] = av[3:2]; cb[1] = bv[3:2];
      ca[2] = av[5:4]; cb[2] = bv[5:4];
      ca[3] = av[7:6]; cb[3] = bv[7:6];
      #1;
      exp_sum = 9'(av) + 9'(bv) + 9'(i[0]);
      got = {cres[3], cres[2], cres[1], result};
      gg = {cg[3], cg[2], cg[1], slice_gen};
      pp = {cp[3], cp[2], cp[1], slice_prop};
      lc = i[0];
      for (int k = 0; k < 4; k++) lc = gg[k] | (pp[k] & lc);
      chk(got == exp_sum[7:0], "R4 cascade sum", got, exp_sum[7:0]);
      chk(cc[3] == exp_sum[8], "R4 cascade ripple carry", cc[3], exp_sum[8]);
      chk(lc == exp_sum[8], "R4 cascade lookahead carry", lc, exp_sum[8]);
    end

    // counter: up with wrap (R5)
    op_a = '0; op_b = '0; carry_in = 1'b0; sub_ctl = 1'b0;
    mode = M_UP; cnt_en = 1'b1;
    exp_cnt = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      exp_cnt = (exp_cnt + 1) % 4;
      chk(result == 2'(exp_cnt), "R5 up count", result, exp_cnt);
      chk(carry_out == (exp_cnt == 3), "R5 up terminal carry", carry_out, int'(exp_cnt == 3));
    end
    tick();
    exp_cnt = (exp_cnt + 1) % 4;  // now 2

    // preload outranks counting (R9)
    cnt_load = 1'b1; op_a = 2'd3;
    tick();
    chk(result == 2'd3, "R9 preload value", result, 3);
    op_a = 2'd1; #1;
    chk(carry_out == 1'b0, "R9 no carry during load", carry_out, 0);
    tick();
    chk(result == 2'd1, "R9 preload over count", result, 1);
    cnt_load = 1'b0;

    // down with wrap (R6)
    mode = M_DN;
    tick();
    chk(result == 2'd0, "R6 down count", result, 0);
    chk(carry_out == 1'b1, "R6 down terminal carry", carry_out, 1);
    tick();
    chk(result == 2'd3, "R6 down wrap", result, 3);

    // run-time direction (R7)
    mode = M_UD; sub_ctl = 1'b0;
    tick();
    chk(result == 2'd0, "R7 up/down going up", result, 0);
    sub_ctl = 1'b1;
    tick();
    chk(result == 2'd3, "R7 up/down going down", result, 3);
    sub_ctl = 1'b0;

    // hold cases (R12)
    mode = M_UP; cnt_en = 1'b0;
    tick();
    chk(result == 2'd3, "R12 hold with enable low", result, 3);
    mode = M_ADD; cnt_en = 1'b1; op_a = 2'd0; op_b = 2'd1;
    tick();
    chk(result == 2'd1, "R12 non-counter mode shows sum", result, 1);
    cnt_load = 1'b1;
    tick();
    cnt_load = 1'b0; cnt_en = 1'b0; mode = M_UP; #1;
    chk(result == 2'd3, "R12 count held outside counter modes", result, 3);

    // asynchronous clear outranks preload (R8)
    @(negedge clk);
    cnt_clr = 1'b1; #1;
    chk(result == 2'd0, "R8 clear without edge", result, 0);
    cnt_load = 1'b1; op_a = 2'd2;
    tick();
    chk(result == 2'd0, "R8 clear over preload", result, 0);
    cnt_clr = 1'b0;
    tick();
    chk(result == 2'd2, "R9 preload after clear", result, 2);
    cnt_load = 1'b0;

    // reset mid-run (R11)
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk(result == 2'd0, "R11 reset mid-run", result, 0);
    tick();
    rst_n = 1'b1;
    tick();

    finish_run();
  end

endmodule